// File: doc/BRIEF.md
# Credit-Gated Flit Link

This block joins a flit source to a flit sink across a point-to-point link whose flow is controlled by credits. The transmit side holds a credit counter that starts at the number of flit slots in the receive buffer. Each flit it sends spends one credit, and it accepts new flits from its local producer only while at least one credit remains. The receive side writes arriving flits into a FIFO. A downstream consumer drains the FIFO through a valid/ready port.

Slots freed by the consumer are not returned one by one. They are counted and handed back as a single multi-credit token. A token is sent as soon as the count of freed slots reaches a set threshold, or as soon as the FIFO runs empty while some freed slots are still unreported. This keeps the control traffic low without leaving credits stranded when traffic stops. The returning token passes through a configurable chain of registers, which stands for the wire length of the link. The whole round trip can therefore be sized against the buffer depth.

Top module: `credit_link_top`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and the transmit side holds exactly `BUF_DEPTH` credits.
- R2: While the credit count is zero, `in_ready` is 0 and no flit is placed on the link.
- R3: Each flit accepted on the input port (`in_valid` and `in_ready` both 1 at a clock edge) spends exactly one credit. With the consumer stalled, exactly `BUF_DEPTH` flits are accepted, and the receive FIFO never overflows.
- R4: Flits leave `out_data` in the order they were accepted, unchanged. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays stable.
- R5: Credits go back only for slots freed by a pop (`out_valid` and `out_ready` both 1). With fewer than `BLOCK_THRESH` pops and the FIFO not empty, no credit returns and `in_ready` stays 0.
- R6: When the number of unreported freed slots reaches `BLOCK_THRESH`, they all return as one token whose amount lies between 1 and `BLOCK_THRESH`. After j pops from a full FIFO that do not empty it, floor(j / `BLOCK_THRESH`) × `BLOCK_THRESH` credits are restored.
- R7: When a pop leaves the FIFO empty, every unreported freed slot returns at once, even if there are fewer than `BLOCK_THRESH` of them.
- R8: When a token arrives in the same cycle as a send, the count becomes old count − 1 + amount. Under continuous traffic no flit is lost or duplicated, and the count never exceeds `BUF_DEPTH`.
- R9: Suppose a pop at clock edge E fires a token while the counter is zero. Then `in_ready` first reads 1 after edge E + `RET_DELAY` + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a flit |
| in_data | input | DATA_W | Flit payload from the producer |
| in_ready | output | 1 | At least one credit is held, so a flit can be taken |
| out_valid | output | 1 | Receive FIFO holds a flit |
| out_data | output | DATA_W | Oldest flit in the receive FIFO |
| out_ready | input | 1 | Consumer takes the flit shown |

## Verification
Five properties are checked on every cycle:
- the credit count never exceeds the buffer depth;
- no flit goes onto the link in a cycle after `in_ready` was low;
- the FIFO has room whenever a flit lands;
- the output holds while stalled;
- every returned token is non-empty and no larger than the threshold.

Three behaviours can only be shown by the bench's scenarios, which observe how many flits the input port takes after each drain pattern and how long recovery takes:
- the exact number of credits restored for each count of pops, swept from one to the full depth;
- the flush when the FIFO goes empty;
- the exact return latency and the conservation of credits under mixed send-and-return traffic.

// File: rtl/clfc_pkg.sv
// Package: shared helpers for the credit-gated flit link.
// Assumes: depths are positive integers.
package clfc_pkg;

    // Bits needed to hold any count from 0 to n inclusive.
    function automatic int count_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Bits needed to index n storage slots.
    function automatic int index_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/clfc_sender.sv
// Transmit side: keeps the credit counter and places accepted flits on the link.
// The counter starts at BUF_DEPTH. Each send spends one credit and each arriving
// token adds its amount, both in the same update. The flit link is one register stage.
// Assumes: a token never carries more credits than were spent.
module clfc_sender #(
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 10,
    parameter int CW        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              tok_valid,
    input  logic [CW-1:0]     tok_amt,
    output logic              link_valid,
    output logic [DATA_W-1:0] link_data,
    output logic [CW-1:0]     credits
);

    localparam logic [CW-1:0] FULL_CREDITS = CW'(BUF_DEPTH);

    logic          send;
    logic [CW:0]   credit_sum;

    // Producer may hand over a flit only while a credit remains.
    assign in_ready = (credits != '0);
    assign send     = in_valid && in_ready;

    // Next count: spend one per send, add the returning token's amount.
    always_comb begin
        credit_sum = {1'b0, credits} - (CW+1)'(send)
                   + (tok_valid ? {1'b0, tok_amt} : '0);
    end

    // Credit counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits <= FULL_CREDITS;
        end else begin
            credits <= credit_sum[CW-1:0];
        end
    end

    // Link register: one flit per cycle toward the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_data  <= '0;
        end else begin
            link_valid <= send;
            if (send) begin
                link_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/clfc_fifo.sv
// Receive buffer: a circular FIFO of BUF_DEPTH flits with a valid/ready read port.
// It also reports the occupancy and whether the FIFO will be empty after this
// cycle's push and pop.
// Assumes: the credit protocol never pushes into a full FIFO.
module clfc_fifo #(
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 10,
    parameter int CW        = 4,
    parameter int AW        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              pop,
    output logic [CW-1:0]     occupancy,
    output logic              empty_next
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(BUF_DEPTH - 1);

    logic [DATA_W-1:0] slots [BUF_DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     occ_next;

    // Read side: head flit is visible whenever the FIFO is not empty.
    assign out_valid = (occupancy != '0);
    assign out_data  = slots[rd_ptr];
    assign pop       = out_valid && out_ready;

    // Occupancy after this cycle's transfers.
    always_comb begin
        occ_next   = occupancy + CW'(push) - CW'(pop);
        empty_next = (occ_next == '0);
    end

    // Pointer and occupancy registers, with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            occupancy <= '0;
        end else begin
            occupancy <= occ_next;
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + AW'(1);
            end
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/clfc_credit_gather.sv
// Credit aggregator: counts slots freed by pops and releases them as one token.
// A token leaves when the count of freed slots reaches BLOCK_THRESH, or when the
// FIFO goes empty with any freed slots still unreported. The token is registered.
// Assumes: BLOCK_THRESH is between 1 and BUF_DEPTH.
module clfc_credit_gather #(
    parameter int BLOCK_THRESH = 5,
    parameter int CW           = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          empty_next,
    output logic          tok_valid,
    output logic [CW-1:0] tok_amt
);

    localparam logic [CW-1:0] THRESH_V = CW'(BLOCK_THRESH);

    logic [CW-1:0] pending;
    logic [CW-1:0] pending_next;
    logic          fire;

    // Decide whether the freed slots, this pop included, go out now.
    always_comb begin
        pending_next = pending + CW'(pop);
        fire = (pending_next >= THRESH_V)
            || (empty_next && (pending_next != '0));
    end

    // Pending count and token register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= '0;
            tok_valid <= 1'b0;
            tok_amt   <= '0;
        end else begin
            tok_valid <= fire;
            tok_amt   <= fire ? pending_next : '0;
            pending   <= fire ? '0 : pending_next;
        end
    end

endmodule

// File: rtl/clfc_delay.sv
// Return path: a chain of DELAY register stages for credit tokens, standing for
// the wire length. With DELAY of zero the token passes straight through.
// Assumes: at most one token enters per cycle.
module clfc_delay #(
    parameter int DELAY = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_amt,
    output logic          out_valid,
    output logic [CW-1:0] out_amt
);

    generate
        if (DELAY == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_amt   = in_amt;
        end else begin : g_pipe
            logic [DELAY-1:0] stage_v;
            logic [CW-1:0]    stage_a [DELAY];

            // Shift the token one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_v <= '0;
                    for (int i = 0; i < DELAY; i++) begin
                        stage_a[i] <= '0;
                    end
                end else begin
                    stage_v[0] <= in_valid;
                    stage_a[0] <= in_amt;
                    for (int i = 1; i < DELAY; i++) begin
                        stage_v[i] <= stage_v[i-1];
                        stage_a[i] <= stage_a[i-1];
                    end
                end
            end

            assign out_valid = stage_v[DELAY-1];
            assign out_amt   = stage_a[DELAY-1];
        end
    endgenerate

endmodule

// File: rtl/credit_link_top.sv
// Top: transmit side, flit link, receive FIFO, credit aggregator and return path.
// Round trip from a pop to a usable credit is RET_DELAY + 2 edges, counting the
// token register, the delay stages and the counter update.
// Assumes: BLOCK_THRESH <= BUF_DEPTH, and the depth covers the round trip
// for full rate.
module credit_link_top #(
    parameter int DATA_W       = 8,
    parameter int BUF_DEPTH    = 10,
    parameter int BLOCK_THRESH = 5,
    parameter int RET_DELAY    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    import clfc_pkg::*;

    localparam int CW = count_bits(BUF_DEPTH);
    localparam int AW = index_bits(BUF_DEPTH);

    logic              link_valid;
    logic [DATA_W-1:0] link_data;
    logic [CW-1:0]     credit_cnt;
    logic              rx_pop;
    logic [CW-1:0]     rx_cnt;
    logic              rx_empty_next;
    logic              ret_valid;
    logic [CW-1:0]     ret_amt;
    logic              dly_valid;
    logic [CW-1:0]     dly_amt;

    clfc_sender #(
        .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .CW(CW)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tok_valid(dly_valid), .tok_amt(dly_amt),
        .link_valid(link_valid), .link_data(link_data),
        .credits(credit_cnt)
    );

    clfc_fifo #(
        .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .CW(CW), .AW(AW)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(link_valid), .push_data(link_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .pop(rx_pop), .occupancy(rx_cnt), .empty_next(rx_empty_next)
    );

    clfc_credit_gather #(
        .BLOCK_THRESH(BLOCK_THRESH), .CW(CW)
    ) u_gather (
        .clk(clk), .rst_n(rst_n),
        .pop(rx_pop), .empty_next(rx_empty_next),
        .tok_valid(ret_valid), .tok_amt(ret_amt)
    );

    clfc_delay #(
        .DELAY(RET_DELAY), .CW(CW)
    ) u_ret (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ret_valid), .in_amt(ret_amt),
        .out_valid(dly_valid), .out_amt(dly_amt)
    );

endmodule

// File: rtl/clfc_chk.sv
// Checker: cycle-by-cycle properties of the credit-gated link, bound to the top.
module clfc_chk #(
    parameter int DATA_W       = 8,
    parameter int BUF_DEPTH    = 10,
    parameter int BLOCK_THRESH = 5,
    parameter int CW           = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              link_valid,
    input logic [CW-1:0]     credit_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic              ret_valid,
    input logic [CW-1:0]     ret_amt
);

    // R8
    credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit_cnt <= CW'(BUF_DEPTH));

    // R2
    no_send_dry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !link_valid);

    // R3
    fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (rx_cnt < CW'(BUF_DEPTH)));

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    token_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((ret_amt != '0) && (ret_amt <= CW'(BLOCK_THRESH))));

endmodule

bind credit_link_top clfc_chk #(
    .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .BLOCK_THRESH(BLOCK_THRESH), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .link_valid(link_valid),
    .credit_cnt(credit_cnt), .rx_cnt(rx_cnt),
    .ret_valid(ret_valid), .ret_amt(ret_amt)
);

// File: tb/sim_credit_link_top.sv
module sim_credit_link_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int DEPTH      = 10;
    localparam int THRESH     = 5;
    localparam int DELAY      = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int tx_seq = 0;
    int rx_seq = 0;
    bit done   = 1'b0;

    credit_link_top #(
        .DATA_W(DW), .BUF_DEPTH(DEPTH), .BLOCK_THRESH(THRESH), .RET_DELAY(DELAY)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer flits for a fixed window; count how many are taken (R3 / R6 / R7).
    task automatic offer(input int cycles, output int taken);
        taken = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (in_ready) begin
                in_valid = 1'b1;
                in_data  = tx_seq[DW-1:0];
                tx_seq++;
                taken++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Pop exactly one flit and check its payload (R4).
    task automatic pop_one();
        @(negedge clk);
        chk(out_valid, "R4 valid before pop", int'(out_valid), 1);
        chk(out_data == rx_seq[DW-1:0], "R4 order", int'(out_data), rx_seq % 256);
        out_ready = 1'b1;
        rx_seq++;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Hold out_ready high for a window, checking every flit leaving (R4).
    task automatic drain(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) begin
                chk(out_data == rx_seq[DW-1:0], "R4 drain order",
                    int'(out_data), rx_seq % 256);
                rx_seq++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..R9 actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int taken;
        int exp;
        int lat;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

        // Sweep of pop counts 1..DEPTH against a full FIFO.
        for (int k = 1; k <= DEPTH; k++) begin
            offer(DEPTH + 5, taken);
            // R3: exactly DEPTH flits accepted with consumer stalled
            chk(taken == DEPTH, "R3 fill count", taken, DEPTH);
            repeat (3) @(negedge clk);
            // R2: no credits left
            chk(!in_ready, "R2 dry", int'(in_ready), 0);
            held = int'(out_data);
            repeat (2) @(negedge clk);
            // R4: stalled output holds
            chk(out_valid && int'(out_data) == held, "R4 hold", int'(out_data), held);
            for (int j = 0; j < k; j++) begin
                pop_one();
            end
            if (k == THRESH) begin
                lat = 0;
                while (!in_ready && lat < 30) begin
                    @(negedge clk);
                    lat++;
                end
                // R9: return latency
                chk(lat == DELAY + 1, "R9 latency", lat, DELAY + 1);
            end
            repeat (20) @(negedge clk);
            if (k < THRESH) begin
                // R5: too few pops, no credit comes back
                chk(!in_ready, "R5 no early credit", int'(in_ready), 0);
            end
            exp = (k == DEPTH) ? DEPTH : (k / THRESH) * THRESH;
            offer(DEPTH + 5, taken);
            // R6: restored credits equal whole blocks (R7 when emptied)
            chk(taken == exp, (k == DEPTH) ? "R7 full drain credits" : "R6 block credits",
                taken, exp);
            drain(60);
            repeat (10) @(negedge clk);
        end

        // R7: a short burst drained to empty returns a partial block.
        offer(3, taken);
        chk(taken == 3, "R7 burst size", taken, 3);
        repeat (3) @(negedge clk);
        drain(10);
        repeat (DELAY + 10) @(negedge clk);
        offer(DEPTH + 5, taken);
        chk(taken == DEPTH, "R7 partial flush", taken, DEPTH);
        drain(60);
        repeat (10) @(negedge clk);

        // R8: continuous send and drain with tokens arriving during sends.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) begin
                chk(out_data == rx_seq[DW-1:0], "R8 stream order",
                    int'(out_data), rx_seq % 256);
                rx_seq++;
            end
            if (in_ready) begin
                in_valid = 1'b1;
                in_data  = tx_seq[DW-1:0];
                tx_seq++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        drain(60);
        chk(rx_seq == tx_seq, "R8 conservation", rx_seq, tx_seq);
        repeat (DELAY + 10) @(negedge clk);
        offer(DEPTH + 5, taken);
        chk(taken == DEPTH, "R8 credits restored", taken, DEPTH);
        drain(60);
        chk(rx_seq == tx_seq, "R8 final count", rx_seq, tx_seq);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule